// File: doc/BRIEF.md
# Write-Any-Read-Legal Control Register

This block is one 32-bit control register whose subfields each follow a write-any-read-legal rule. Software may write any pattern. Each subfield passes through its own legalizing function before the clock edge, so the flop contents are always legal. The same stored word feeds both the software read port and the hardware-facing output. No consumer can ever see an illegal value, and both views always agree.

The register holds six subfields. The first is a two-bit vector mode. Next to it is a vector base, whose required alignment depends on that mode. The third is a field that is tied to zero. The fourth is a range field, and an elaboration parameter picks how it corrects an out-of-range write: smallest, largest or nearest legal value. The fifth is a bounded field that refuses illegal writes. The sixth is a mask/value field that takes written bits only where a mask allows. Every correction depends only on the written word and on the register's present contents.

Top module: `warl_csr`

## Requirements
- R1: After a synchronous active-low reset, rd_data and hw_csr read 0x9020_0000 with default parameters. In that value, mode=00, base=0, the zero field is 0, range=2, bounded=0 and mask/value=4'b1001.
- R2: A fully legal write with wr_en=1 appears unchanged on rd_data and hw_csr after the next rising clock edge. Both outputs always carry the same value.
- R3: The zero field, bits [19:16], always reads 0, whatever is written.
- R4: The bounded field, bits [27:24], is legal from 0 to HOLD_MAX (default 9). An illegal write leaves its old value in place.
- R5: The range field, bits [23:20], is legal in [RNG_LO0,RNG_HI0] ∪ [RNG_LO1,RNG_HI1] (default [2,5] ∪ [9,12]). A legal write is stored as written. An illegal write becomes the smallest legal value (2) when RNG_POLICY=0 and the largest (12) when RNG_POLICY=1.
- R6: When RNG_POLICY=2 (the default), an illegal range write becomes the nearest legal value. When two legal values are equally distant, the lower one is chosen: 7 gives 5, 6 gives 5, 8 gives 9, 0 gives 2, 15 gives 12, 14 gives 12.
- R7: The mask/value field, bits [31:28], stores (wr & MV_MASK) | (MV_VAL & ~MV_MASK). The defaults are MV_MASK=4'b0110 and MV_VAL=4'b1001.
- R8: The mode field, bits [1:0], accepts only 00 and 01. A write of 10 or 11 leaves the mode unchanged.
- R9: The base field, bits [15:2], is legalized against the resulting mode in the same write. With mode 01, base bits [5:2] are cleared, which gives 64-byte alignment. With mode 00, every base bit is kept, which is 4-byte alignment.
- R10: While wr_en=0, the register holds its value, whatever wr_data carries.
- R11: Subfields are legalized independently. A single write that is illegal in several fields corrects each field by its own rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Software read value |
| hw_csr | output | 32 | Value used by hardware |

## Verification
The bench first writes fully legal words to show that they come back unchanged. It then writes words that are illegal in one field at a time, so that each field's correction rule is separated from the others. Three instances differ only in range policy and receive identical writes, which tells apart smallest, largest and nearest correction, including the equal-distance tie. Mode writes of 10 and 11 are applied from both legal modes. These writes show that the base is aligned against the mode that is kept, not the mode written. One final write is illegal in every field at once, and confirms that the corrections do not interfere.

// File: rtl/warl_csr.sv
module warl_csr #(
  parameter int BASE_W     = 14,
  parameter int FLD_W      = 4,
  parameter int ALIGN_BITS = 4,
  parameter int RNG_LO0    = 2,
  parameter int RNG_HI0    = 5,
  parameter int RNG_LO1    = 9,
  parameter int RNG_HI1    = 12,
  parameter int RNG_POLICY = 2,
  parameter int HOLD_MAX   = 9,
  parameter logic [3:0] MV_MASK = 4'b0110,
  parameter logic [3:0] MV_VAL  = 4'b1001,
  localparam int MODE_W   = 2,
  localparam int BASE_LSB = MODE_W,
  localparam int ZERO_LSB = BASE_LSB + BASE_W,
  localparam int RNG_LSB  = ZERO_LSB + FLD_W,
  localparam int HOLD_LSB = RNG_LSB + FLD_W,
  localparam int MV_LSB   = HOLD_LSB + FLD_W,
  localparam int W        = MV_LSB + FLD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] hw_csr
);

  logic [MODE_W-1:0] mode_q, mode_nx;
  logic [BASE_W-1:0] base_q, base_nx;
  logic [FLD_W-1:0]  rng_q, rng_nx, rng_fix;
  logic [FLD_W-1:0]  hold_q, hold_nx;
  logic [FLD_W-1:0]  mv_q, mv_nx;

  wire [MODE_W-1:0] w_mode = wr_data[BASE_LSB-1:0];
  wire [BASE_W-1:0] w_base = wr_data[ZERO_LSB-1:BASE_LSB];
  wire [FLD_W-1:0]  w_rng  = wr_data[HOLD_LSB-1:RNG_LSB];
  wire [FLD_W-1:0]  w_hold = wr_data[MV_LSB-1:HOLD_LSB];
  wire [FLD_W-1:0]  w_mv   = wr_data[W-1:MV_LSB];

  assign mode_nx = w_mode[1] ? mode_q : w_mode;
  assign base_nx = (mode_nx == 2'b01) ?
                   {w_base[BASE_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}} : w_base;

  wire rng_ok = (int'(w_rng) >= RNG_LO0 && int'(w_rng) <= RNG_HI0) ||
                (int'(w_rng) >= RNG_LO1 && int'(w_rng) <= RNG_HI1);

  generate
    if (RNG_POLICY == 0) begin : g_small
      assign rng_fix = FLD_W'(RNG_LO0);
    end else if (RNG_POLICY == 1) begin : g_large
      assign rng_fix = FLD_W'(RNG_HI1);
    end else begin : g_near
      always_comb begin
        if (int'(w_rng) < RNG_LO0)
          rng_fix = FLD_W'(RNG_LO0);
        else if (int'(w_rng) > RNG_HI1)
          rng_fix = FLD_W'(RNG_HI1);
        else if ((int'(w_rng) - RNG_HI0) <= (RNG_LO1 - int'(w_rng)))
          rng_fix = FLD_W'(RNG_HI0);
        else
          rng_fix = FLD_W'(RNG_LO1);
      end
    end
  endgenerate

  assign rng_nx  = rng_ok ? w_rng : rng_fix;
  assign hold_nx = (int'(w_hold) <= HOLD_MAX) ? w_hold : hold_q;
  assign mv_nx   = (w_mv & MV_MASK) | (MV_VAL & ~MV_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      base_q <= '0;
      rng_q  <= FLD_W'(RNG_LO0);
      hold_q <= '0;
      mv_q   <= MV_VAL & ~MV_MASK;
    end else if (wr_en) begin
      mode_q <= mode_nx;
      base_q <= base_nx;
      rng_q  <= rng_nx;
      hold_q <= hold_nx;
      mv_q   <= mv_nx;
    end
  end

  wire [W-1:0] csr_word = {mv_q, hold_q, rng_q, {FLD_W{1'b0}}, base_q, mode_q};
  assign rd_data = csr_word;
  assign hw_csr  = csr_word;

endmodule

// File: rtl/warl_csr_chk.sv
module warl_csr_chk #(
  parameter int W = 32,
  parameter int ZERO_LSB = 16,
  parameter int RNG_LSB = 20,
  parameter int HOLD_LSB = 24,
  parameter int MV_LSB = 28,
  parameter int ALIGN_BITS = 4,
  parameter int RNG_LO0 = 2,
  parameter int RNG_HI0 = 5,
  parameter int RNG_LO1 = 9,
  parameter int RNG_HI1 = 12,
  parameter int HOLD_MAX = 9,
  parameter logic [3:0] MV_MASK = 4'b0110,
  parameter logic [3:0] MV_VAL = 4'b1001
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] hw_csr
);
  wire [3:0] c_rng  = rd_data[RNG_LSB+3:RNG_LSB];
  wire [3:0] c_hold = rd_data[HOLD_LSB+3:HOLD_LSB];
  wire [3:0] c_mv   = rd_data[MV_LSB+3:MV_LSB];

  assert_views_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_csr == rd_data);
  assert_zero_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ZERO_LSB+3:ZERO_LSB] == 4'd0);
  assert_hold_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(c_hold) <= HOLD_MAX);
  assert_range_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(c_rng) >= RNG_LO0 && int'(c_rng) <= RNG_HI0) ||
    (int'(c_rng) >= RNG_LO1 && int'(c_rng) <= RNG_HI1));
  assert_mask_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mv & ~MV_MASK) == (MV_VAL & ~MV_MASK));
  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] == 1'b0);
  assert_base_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b01) |-> (rd_data[2+ALIGN_BITS-1:2] == '0));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

bind warl_csr warl_csr_chk #(
  .W(W), .ZERO_LSB(ZERO_LSB), .RNG_LSB(RNG_LSB), .HOLD_LSB(HOLD_LSB),
  .MV_LSB(MV_LSB), .ALIGN_BITS(ALIGN_BITS), .RNG_LO0(RNG_LO0), .RNG_HI0(RNG_HI0),
  .RNG_LO1(RNG_LO1), .RNG_HI1(RNG_HI1), .HOLD_MAX(HOLD_MAX),
  .MV_MASK(MV_MASK), .MV_VAL(MV_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data), .hw_csr(hw_csr)
);

// File: tb/sim_warl_csr.sv
module sim_warl_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0, hw0, rd1, hw1, rd2, hw2;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  warl_csr #(.RNG_POLICY(2)) u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd0), .hw_csr(hw0));
  warl_csr #(.RNG_POLICY(0)) u1 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd1), .hw_csr(hw1));
  warl_csr #(.RNG_POLICY(1)) u2 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd2), .hw_csr(hw2));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_R1;
    check("R1 rd", rd0, 32'h9020_0000);
    check("R1 hw", hw0, 32'h9020_0000);
  endtask

  task automatic t_legal_R2;
    wr(32'hF740_04C1);
    check("R2 rd", rd0, 32'hF740_04C1);
    check("R2 hw", hw0, 32'hF740_04C1);
  endtask

  task automatic t_zero_R3;
    wr(32'hF74F_04C1);
    check("R3", rd0, 32'hF740_04C1);
  endtask

  task automatic t_hold_R4;
    wr(32'hFC40_04C1);
    check("R4 illegal kept", rd0, 32'hF740_04C1);
    wr(32'hF940_04C1);
    check("R4 max legal", rd0, 32'hF940_04C1);
  endtask

  task automatic t_range_R5;
    wr(32'hF980_04C1);
    check("R6 nearest 8", rd0, 32'hF990_04C1);
    check("R5 smallest", rd1, 32'hF920_04C1);
    check("R5 largest", rd2, 32'hF9C0_04C1);
    wr(32'hF9B0_04C1);
    check("R5 legal u0", rd0, 32'hF9B0_04C1);
    check("R5 legal u1", rd1, 32'hF9B0_04C1);
    check("R5 legal u2", rd2, 32'hF9B0_04C1);
  endtask

  task automatic t_nearest_R6;
    wr(32'hF970_04C1);
    check("R6 tie 7", rd0, 32'hF950_04C1);
    wr(32'hF900_04C1);
    check("R6 low 0", rd0, 32'hF920_04C1);
    wr(32'hF9F0_04C1);
    check("R6 high 15", rd0, 32'hF9C0_04C1);
    wr(32'hF960_04C1);
    check("R6 gap 6", rd0, 32'hF950_04C1);
  endtask

  task automatic t_mask_R7;
    wr(32'h0950_04C1);
    check("R7 zeros", rd0, 32'h9950_04C1);
    wr(32'h4950_04C1);
    check("R7 one bit", rd0, 32'hD950_04C1);
  endtask

  task automatic t_mode_R8;
    wr(32'h9950_030E);
    check("R8 mode 10 held 01", rd0, 32'h9950_0301);
    wr(32'h9950_030C);
    check("R9 mode 00 keeps base", rd0, 32'h9950_030C);
    wr(32'h9950_030F);
    check("R8 mode 11 held 00", rd0, 32'h9950_030C);
  endtask

  task automatic t_align_R9;
    wr(32'h9950_030D);
    check("R9 mode 01 aligns", rd0, 32'h9950_0301);
    wr(32'h9950_FFFC);
    check("R9 mode 00 full base", rd0, 32'h9950_FFFC);
  endtask

  task automatic t_idle_R10;
    @(negedge clk);
    wr_data = 32'h0000_0001;
    repeat (4) @(negedge clk);
    check("R10 idle", rd0, 32'h9950_FFFC);
  endtask

  task automatic t_indep_R11;
    wr(32'h9320_0000);
    check("R11 setup", rd0, 32'h9320_0000);
    wr(32'h0FEF_FFFF);
    check("R11 nearest", rd0, 32'h93C0_FFFC);
    check("R11 smallest", rd1, 32'h9320_FFFC);
    check("R11 largest", rd2, 32'h93C0_FFFC);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R1();
    t_legal_R2();
    t_zero_R3();
    t_hold_R4();
    t_range_R5();
    t_nearest_R6();
    t_mask_R7();
    t_mode_R8();
    t_align_R9();
    t_idle_R10();
    t_indep_R11();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule